// File: doc/BRIEF.md
# Segmented Approximate Adder with Speculative Boundary Carries

This block adds two N-bit operands with a bounded carry chain. The operands are covered by a series of short exact adder windows, each K bits wide. The first window sits at the most significant end. Each following window starts K−L bits lower, so neighbouring windows share L bits. A window writes only its upper K−L sum bits. Its lower L bits serve only to build up the carry for those upper bits. Any low-order bits that no full window reaches are summed by one narrower exact adder at the bottom.

A parameter picks how each window gets its carry-in. In the zero-carry scheme, every window starts with carry-in 0. In the AND-carry scheme, each window takes as its carry-in the AND of the two operand bits just below its bottom bit. That bit is an approximate full adder: its carry-out ignores its own carry-in. The guess is therefore right more often than a constant zero, and the carry chain stays no longer than K bits.

The sum and carry-out are registered, so results appear one clock after the operands. A synchronous active-high reset clears both outputs.

Top module: `saa_adder_top`

## Requirements
- R1: Windows are placed from the MSB down with a step of S=K−L. Window i spans bits N−1−i·S down to N−K−i·S, and drives sum bits N−1−i·S down to N−S−i·S. The bits H−1..0, where H = N − M·S and M = (N−K)/S + 1, are summed exactly with carry-in 0.
- R2: With MODE=CARRY_ZERO, every window adds its operand slices with carry-in 0. For N=8, K=3, L=1, the inputs a=0x03, b=0x01 give sum 0x00 and cout 0.
- R3: With MODE=CARRY_AND, a window whose bottom bit index p is above 0 takes carry-in a[p−1]&b[p−1]. A window with p=0 takes carry-in 0. For N=8, K=3, L=1, the inputs a=0x03, b=0x01 give sum 0x04.
- R4: cout equals the carry out of the most significant window.
- R5: When K=N, sum and cout equal the exact N+1-bit sum a+b, whatever the values of L and MODE.
- R6: When a&b has no bit set, sum equals a^b and cout is 0 in both modes.
- R7: sum and cout are registered and show the result for the operands present at the previous rising clock edge. A synchronous active-high rst clears both to 0.
- R8: Over all 65536 operand pairs with N=8, K=3, L=1, the AND-carry scheme gives the exact result at least as often as the zero-carry scheme.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | N | First operand |
| b | input | N | Second operand |
| sum | output | N | Registered approximate sum |
| cout | output | 1 | Registered carry out of the top window |

## Verification
Every result is due exactly one rising edge after its operands are applied, because the only registers are the output registers. The bench drives a new operand pair at each falling edge. At the next falling edge it compares the registered outputs with the model's value for the pair driven one cycle earlier, so each pair is checked in its own cycle during the full exhaustive sweep. The reset check holds nonzero operands during reset and expects zeros. The first check after reset expects the result of the operands driven during the last reset cycle.

// File: rtl/saa_pkg.sv
package saa_pkg;

  typedef enum logic {
    CARRY_ZERO = 1'b0,
    CARRY_AND  = 1'b1
  } spec_mode_e;

  // number of full K-bit windows placed from the MSB with step K-L
  function automatic int seg_count(input int n, input int k, input int l);
    return (n - k) / (k - l) + 1;
  endfunction

  // low-order bits left for the narrow bottom adder
  function automatic int lsb_width(input int n, input int k, input int l);
    return n - seg_count(n, k, l) * (k - l);
  endfunction

endpackage

// File: rtl/saa_cells.sv
module saa_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ ci;
  assign co = (x & y) | (ci & (x ^ y));
endmodule

module saa_carry_cell (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic co
);
  assign co = (x & y) | (ci & (x | y));
endmodule

module saa_spec_carry #(
  parameter saa_pkg::spec_mode_e MODE = saa_pkg::CARRY_AND
) (
  input  logic x,
  input  logic y,
  output logic c
);
  generate
    if (MODE == saa_pkg::CARRY_AND) begin : g_and
      assign c = x & y;
    end else begin : g_zero
      logic pair_unused;
      assign pair_unused = x ^ y;
      assign c = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/saa_seg.sv
module saa_seg #(
  parameter int W     = 8,
  parameter int OUT_W = 4
) (
  input  logic [W-1:0]     x,
  input  logic [W-1:0]     y,
  input  logic             ci,
  output logic [OUT_W-1:0] s_hi,
  output logic             co
);
  localparam int LOW_W = W - OUT_W;

  logic [W:0] c;
  assign c[0] = ci;

  generate
    for (genvar j = 0; j < W; j++) begin : g_bit
      if (j < LOW_W) begin : g_carry_only
        saa_carry_cell u_cc (
          .x (x[j]),
          .y (y[j]),
          .ci(c[j]),
          .co(c[j+1])
        );
      end else begin : g_full
        saa_fa u_fa (
          .x (x[j]),
          .y (y[j]),
          .ci(c[j]),
          .s (s_hi[j-LOW_W]),
          .co(c[j+1])
        );
      end
    end
  endgenerate

  assign co = c[W];
endmodule

// File: rtl/saa_core.sv
module saa_core #(
  parameter int N = 32,
  parameter int K = 8,
  parameter int L = 4,
  parameter saa_pkg::spec_mode_e MODE = saa_pkg::CARRY_AND
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] sum,
  output logic         cout
);
  localparam int S = K - L;
  localparam int M = saa_pkg::seg_count(N, K, L);
  localparam int H = saa_pkg::lsb_width(N, K, L);

  generate
    for (genvar i = 0; i < M; i++) begin : g_win
      localparam int TOP = N - 1 - i * S;
      localparam int BOT = TOP - K + 1;
      localparam int GP  = (BOT > 0) ? BOT - 1 : 0;

      logic         cin;
      logic         co;
      logic [S-1:0] hi;

      if (BOT > 0) begin : g_spec
        saa_spec_carry #(.MODE(MODE)) u_spec (
          .x(a[GP]),
          .y(b[GP]),
          .c(cin)
        );
      end else begin : g_base
        assign cin = 1'b0;
      end

      saa_seg #(.W(K), .OUT_W(S)) u_seg (
        .x   (a[TOP:BOT]),
        .y   (b[TOP:BOT]),
        .ci  (cin),
        .s_hi(hi),
        .co  (co)
      );

      assign sum[TOP -: S] = hi;

      if (i == 0) begin : g_msb
        assign cout = co;
      end else begin : g_inner
        logic co_unused;
        assign co_unused = co;
      end
    end

    if (H > 0) begin : g_lsb
      logic lsb_co_unused;
      saa_seg #(.W(H), .OUT_W(H)) u_lsb (
        .x   (a[H-1:0]),
        .y   (b[H-1:0]),
        .ci  (1'b0),
        .s_hi(sum[H-1:0]),
        .co  (lsb_co_unused)
      );
    end
  endgenerate
endmodule

// File: rtl/saa_adder_top.sv
module saa_adder_top #(
  parameter int N = 32,
  parameter int K = 8,
  parameter int L = 4,
  parameter saa_pkg::spec_mode_e MODE = saa_pkg::CARRY_AND
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] sum,
  output logic         cout
);
  logic [N-1:0] sum_d;
  logic         cout_d;

  saa_core #(.N(N), .K(K), .L(L), .MODE(MODE)) u_core (
    .a   (a),
    .b   (b),
    .sum (sum_d),
    .cout(cout_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
    end else begin
      sum  <= sum_d;
      cout <= cout_d;
    end
  end
endmodule

// File: rtl/saa_adder_chk.sv
module saa_adder_chk #(
  parameter int N = 32,
  parameter int K = 8,
  parameter int L = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] a,
  input logic [N-1:0] b,
  input logic [N-1:0] sum,
  input logic         cout
);
  localparam int H = saa_pkg::lsb_width(N, K, L);

  logic live_q;
  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  // R7
  rst_clear_chk: assert property (@(posedge clk) rst |=> (sum == '0 && !cout));

  // R6
  no_gen_exact_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past((a & b) == '0)) |-> (sum == $past(a ^ b) && !cout));

  // R4
  cout_gen_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(a[N-1] & b[N-1])) |-> cout);

  // R4
  cout_kill_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(!a[N-1] && !b[N-1])) |-> !cout);

  generate
    if (H > 0) begin : g_lsb_chk
      logic [H-1:0] low_exact;
      assign low_exact = a[H-1:0] + b[H-1:0];
      // R1
      lsb_exact_chk: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (sum[H-1:0] == $past(low_exact)));
    end
  endgenerate
endmodule

bind saa_adder_top saa_adder_chk #(.N(N), .K(K), .L(L)) chk_i (
  .clk (clk),
  .rst (rst),
  .a   (a),
  .b   (b),
  .sum (sum),
  .cout(cout)
);

// File: tb/saa_adder_tb.sv
`timescale 1ns/1ps
module saa_adder_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a = 8'hFF;
  logic [7:0] b = 8'hFF;

  logic [7:0] s_dut, s_base, s_disj, s_full;
  logic       c_dut, c_base, c_disj, c_full;

  int vectors = 0;
  int errs    = 0;
  int pass_and  = 0;
  int pass_zero = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  saa_adder_top #(.N(8), .K(3), .L(1), .MODE(saa_pkg::CARRY_AND)) dut_i (
    .clk(clk), .rst(rst), .a(a), .b(b), .sum(s_dut), .cout(c_dut));
  saa_adder_top #(.N(8), .K(3), .L(1), .MODE(saa_pkg::CARRY_ZERO)) base_i (
    .clk(clk), .rst(rst), .a(a), .b(b), .sum(s_base), .cout(c_base));
  saa_adder_top #(.N(8), .K(3), .L(0), .MODE(saa_pkg::CARRY_AND)) disj_i (
    .clk(clk), .rst(rst), .a(a), .b(b), .sum(s_disj), .cout(c_disj));
  saa_adder_top #(.N(8), .K(8), .L(2), .MODE(saa_pkg::CARRY_AND)) full_i (
    .clk(clk), .rst(rst), .a(a), .b(b), .sum(s_full), .cout(c_full));

  // behavioural model of the windowed scheme, 8-bit operands
  function automatic logic [8:0] model(int x, int y, int k, int l, int use_and);
    int s, m, h, top, bot, cin, v, res, co;
    s = k - l;
    m = (8 - k) / s + 1;
    h = 8 - m * s;
    res = 0;
    co = 0;
    for (int i = 0; i < m; i++) begin
      top = 7 - i * s;
      bot = top - k + 1;
      cin = (use_and != 0 && bot > 0) ? (((x >> (bot - 1)) & (y >> (bot - 1))) & 1) : 0;
      v = ((x >> bot) & ((1 << k) - 1)) + ((y >> bot) & ((1 << k) - 1)) + cin;
      res = res | (((v >> (k - s)) & ((1 << s) - 1)) << (top - s + 1));
      if (i == 0) co = (v >> k) & 1;
    end
    if (h > 0) res = res | (((x & ((1 << h) - 1)) + (y & ((1 << h) - 1))) & ((1 << h) - 1));
    return {co[0], res[7:0]};
  endfunction

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
  endtask

  task automatic compare_all(int x, int y);
    logic [8:0] exact;
    exact = 9'(x + y);
    chk("R1 R3 R4 window/and-carry", {c_dut, s_dut}, model(x, y, 3, 1, 1));
    chk("R2 R4 zero-carry", {c_base, s_base}, model(x, y, 3, 1, 0));
    chk("R1 R3 disjoint windows", {c_disj, s_disj}, model(x, y, 3, 0, 1));
    chk("R5 full-width exact", {c_full, s_full}, exact);
    if ((x & y) == 0)
      chk("R6 no-generate exact", {c_dut, s_dut}, {1'b0, 8'(x ^ y)});
    if ({c_dut, s_dut} === exact) pass_and++;
    if ({c_base, s_base} === exact) pass_zero++;
  endtask

  initial begin
    int pa, pb;
    bit have;
    repeat (3) @(negedge clk);
    // R7: reset clears outputs while operands are nonzero
    chk("R7 reset dut", {c_dut, s_dut}, 9'h000);
    chk("R7 reset base", {c_base, s_base}, 9'h000);
    rst = 1'b0;
    @(negedge clk);
    // R7: first result is from operands held at the release edge
    chk("R7 latency", {c_dut, s_dut}, model(255, 255, 3, 1, 1));
    a = 8'h03; b = 8'h01;
    @(negedge clk);
    chk("R3 directed 03+01", {c_dut, s_dut}, 9'h004);
    chk("R2 directed 03+01", {c_base, s_base}, 9'h000);
    chk("R5 directed 03+01", {c_full, s_full}, 9'h004);
    a = 8'h80; b = 8'h80;
    @(negedge clk);
    chk("R4 top generate", {c_dut, s_dut}, model(128, 128, 3, 1, 1));
    chk("R4 cout set", {8'h00, c_dut}, 9'h001);
    have = 0;
    pa = 0; pb = 0;
    for (int v = 0; v < 65536; v++) begin
      @(negedge clk);
      if (have) compare_all(pa, pb);
      pa = v >> 8;
      pb = v & 255;
      a = 8'(pa);
      b = 8'(pb);
      have = 1;
    end
    @(negedge clk);
    compare_all(pa, pb);
    vectors++;
    if (pass_and < pass_zero) begin
      errs++;
      $display("FAIL R8 pass count act=%0d exp>=%0d", pass_and, pass_zero);
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL R7 watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end
endmodule